// File: doc/BRIEF.md
# Host-Port Interrupt and Read Arbiter

This block sits behind a byte-wide strobed slave port that an external master uses to talk to a peripheral controller. It collects one-cycle event pulses (power-up self-test finished, enumeration finished, bus reset, bus resume, wakeup pin) into an interrupt status byte. It drives an active-low interrupt line from the status bits whose enables are set.

When the master starts a command-register read, the block decides what the next read strobe returns. If an enabled interrupt is already pending, the next strobe returns the status byte. Otherwise it returns the requested register value. The `ready` output tells the master which of the two it will get.

While a read request is open, newly arriving events are parked in a side buffer. They are merged into the status byte only when the request completes. The read strobe is asynchronous to the block clock and passes through a two-flop synchronizer. The falling edge selects and latches the byte, and the rising edge completes the access.

Top module: `hpi_irq_arb`

## Requirements
- R1: After reset `int_n` is 1, `ready` is 0, `resume_req` is 0 and `rd_data` is 0.
- R2: A `selftest_done` pulse sets status bit 0 when `desc_present` is 0. When `desc_present` is 1, it sets status bit 1 instead and leaves bit 0 unchanged.
- R3: A `wake_pin` pulse sets status bit 0. A `bus_resume` pulse sets status bit 2. An `enum_done` or `bus_reset` pulse sets status bit 1. No event sets bits 7..3.
- R4: `int_n` is low exactly when some status bit is set whose matching `irq_en` bit is 1. A status bit whose enable is 0 still records its event and is returned by a status read.
- R5: With no read request open, a read strobe returns the status byte on `rd_data` (bit 0 ready source, bit 1 enumeration, bit 2 bus activity). Completing that access clears exactly the bits it returned; events that arrive during the access stay set.
- R6: A `rd_req` pulse with no enabled bit pending raises `ready` at once. The next strobe returns the `req_data` value captured with the request, and completing that strobe ends the request and drops `ready`.
- R7: A `rd_req` pulse while an enabled bit is pending keeps `ready` low. The next strobe returns the status byte and clears the bits it returned. `ready` then rises, and the strobe after that returns the captured `req_data`.
- R8: Events that arrive while a read request is open do not change the status byte or `int_n`. They are merged into the status byte when the request's data strobe completes.
- R9: `resume_req` pulses high in the cycle after a `wake_pin` pulse when `remote_wake_en` is 1. It stays low when `remote_wake_en` is 0.
- R10: A `rd_req` pulse while a request is already open is ignored: the captured data and the read order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selftest_done | input | 1 | Pulse: power-up self-test finished |
| desc_present | input | 1 | Valid external descriptor store is present |
| enum_done | input | 1 | Pulse: enumeration finished |
| bus_reset | input | 1 | Pulse: bus reset detected, re-enumeration done |
| bus_resume | input | 1 | Pulse: left low power because of bus resume |
| wake_pin | input | 1 | Pulse: left low power because of wakeup pin |
| remote_wake_en | input | 1 | Host has enabled remote wakeup |
| irq_en | input | 8 | Per-bit interrupt enables |
| rd_req | input | 1 | Pulse: master starts a command-register read |
| req_data | input | DW | Register value, captured with `rd_req` |
| rd_strobe_n | input | 1 | Asynchronous active-low read strobe |
| rd_data | output | DW | Byte returned by the last read strobe |
| int_n | output | 1 | Active-low interrupt line |
| ready | output | 1 | High when the next strobe returns register data |
| resume_req | output | 1 | One-cycle request for resume signalling |

## Verification
Each event source is pulsed alone, and under both `desc_present` values, to tell the self-test routing apart from the wake, resume and enumeration routes. Read requests are issued with and without an enabled pending bit. This separates the data-first order from the status-first order and shows the `ready` level the master relies on. Events injected while a request is open show whether they are parked or leak early into `int_n`. A random mix of enables, event kinds and read styles, checked against a bench-side model, covers disabled-but-recorded bits and partial clears.

// File: rtl/hpi_irq_pkg.sv
package hpi_irq_pkg;

  localparam int unsigned SW = 8;

  localparam int unsigned BIT_RDY    = 0;
  localparam int unsigned BIT_ENUM   = 1;
  localparam int unsigned BIT_BUSACT = 2;

  typedef logic [SW-1:0] stat_t;

  // Maps event pulses onto status bits.
  function automatic stat_t map_events(input logic selftest, input logic desc,
                                       input logic enum_ok, input logic brst,
                                       input logic resume, input logic wake);
    stat_t b;
    b = '0;
    b[BIT_RDY]    = (selftest & ~desc) | wake;
    b[BIT_ENUM]   = (selftest & desc) | enum_ok | brst;
    b[BIT_BUSACT] = resume;
    return b;
  endfunction

  // Chooses whether a strobe returns the status byte (1) or register data (0).
  function automatic logic strobe_gives_status(input logic sess, input logic status_first);
    return ~sess | status_first;
  endfunction

  // Status byte after a completed status read.
  function automatic stat_t clear_reported(input stat_t cur, input stat_t reported);
    return cur & ~reported;
  endfunction

endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= strobe_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];
  assign rise = ~last_q & chain_q[STAGES-1];

endmodule

// File: rtl/hpi_event_router.sv
module hpi_event_router
  import hpi_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  selftest_done,
  input  logic  desc_present,
  input  logic  enum_done,
  input  logic  bus_reset,
  input  logic  bus_resume,
  input  logic  wake_pin,
  input  logic  remote_wake_en,
  output stat_t ev_bits,
  output logic  resume_req
);

  assign ev_bits = map_events(selftest_done, desc_present, enum_done,
                              bus_reset, bus_resume, wake_pin);

  always_ff @(posedge clk) begin
    if (!rst_n) resume_req <= 1'b0;
    else        resume_req <= wake_pin & remote_wake_en;
  end

endmodule

// File: rtl/hpi_read_arb.sv
module hpi_read_arb
  import hpi_irq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [DW-1:0] req_data,
  input  logic          fall,
  input  logic          rise,
  input  stat_t         ev_bits,
  input  stat_t         irq_en,
  output stat_t         stat_q,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          int_n,
  output logic          sess_active
);

  localparam int unsigned PADW = DW - SW;

  logic          sess_q, smode_q, acc_q, acc_stat_q;
  stat_t         held_q, rep_q;
  logic [DW-1:0] req_q, rd_q;

  logic  start, pend, done, stat_done, data_done, sess_n, smode_n, give_stat;
  stat_t stat_n, held_n;
  logic [DW-1:0] stat_wide;

  generate
    if (PADW > 0) begin : g_pad
      assign stat_wide = {{PADW{1'b0}}, stat_q};
    end else begin : g_nopad
      assign stat_wide = stat_q[DW-1:0];
    end
  endgenerate

  always_comb begin
    start     = rd_req & ~sess_q;
    pend      = |(stat_q & irq_en);
    done      = rise & acc_q;
    stat_done = done & acc_stat_q;
    data_done = done & ~acc_stat_q;
    give_stat = strobe_gives_status(sess_q, smode_q);
    sess_n    = (sess_q & ~data_done) | start;

    if (start)          smode_n = pend;
    else if (stat_done) smode_n = 1'b0;
    else                smode_n = smode_q;

    stat_n = stat_q;
    if (stat_done) stat_n = clear_reported(stat_n, rep_q);
    if (data_done) stat_n = stat_n | held_q;
    if (!sess_n)   stat_n = stat_n | ev_bits;

    held_n = data_done ? '0 : held_q;
    if (sess_n) held_n = held_n | ev_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sess_q     <= 1'b0;
      smode_q    <= 1'b0;
      acc_q      <= 1'b0;
      acc_stat_q <= 1'b0;
      held_q     <= '0;
      rep_q      <= '0;
      stat_q     <= '0;
      req_q      <= '0;
      rd_q       <= '0;
    end else begin
      sess_q  <= sess_n;
      smode_q <= smode_n;
      stat_q  <= stat_n;
      held_q  <= held_n;
      if (start) req_q <= req_data;
      if (fall) begin
        acc_q      <= 1'b1;
        acc_stat_q <= give_stat;
        if (give_stat) begin
          rd_q  <= stat_wide;
          rep_q <= stat_q;
        end else begin
          rd_q  <= req_q;
          rep_q <= '0;
        end
      end else if (done) begin
        acc_q <= 1'b0;
      end
    end
  end

  assign rd_data     = rd_q;
  assign ready       = sess_q & ~smode_q;
  assign int_n       = ~pend;
  assign sess_active = sess_q;

endmodule

// File: rtl/hpi_irq_arb.sv
module hpi_irq_arb
  import hpi_irq_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          selftest_done,
  input  logic          desc_present,
  input  logic          enum_done,
  input  logic          bus_reset,
  input  logic          bus_resume,
  input  logic          wake_pin,
  input  logic          remote_wake_en,
  input  logic [7:0]    irq_en,
  input  logic          rd_req,
  input  logic [DW-1:0] req_data,
  input  logic          rd_strobe_n,
  output logic [DW-1:0] rd_data,
  output logic          int_n,
  output logic          ready,
  output logic          resume_req
);

  stat_t ev_bits;
  stat_t stat_q;
  logic  fall_evt, rise_evt, sess_active;

  hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (rd_strobe_n),
    .fall     (fall_evt),
    .rise     (rise_evt)
  );

  hpi_event_router u_route (
    .clk            (clk),
    .rst_n          (rst_n),
    .selftest_done  (selftest_done),
    .desc_present   (desc_present),
    .enum_done      (enum_done),
    .bus_reset      (bus_reset),
    .bus_resume     (bus_resume),
    .wake_pin       (wake_pin),
    .remote_wake_en (remote_wake_en),
    .ev_bits        (ev_bits),
    .resume_req     (resume_req)
  );

  hpi_read_arb #(.DW(DW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .req_data    (req_data),
    .fall        (fall_evt),
    .rise        (rise_evt),
    .ev_bits     (ev_bits),
    .irq_en      (irq_en),
    .stat_q      (stat_q),
    .rd_data     (rd_data),
    .ready       (ready),
    .int_n       (int_n),
    .sess_active (sess_active)
  );

endmodule

// File: rtl/hpi_irq_arb_chk.sv
module hpi_irq_arb_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_n,
  input logic          ready,
  input logic          resume_req,
  input logic [DW-1:0] rd_data,
  input logic          wake_pin,
  input logic          remote_wake_en,
  input logic          sess_active,
  input logic [7:0]    stat_q,
  input logic          fall_evt
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (int_n && !ready && !resume_req));

  p_resume_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(wake_pin && remote_wake_en));

  p_ready_needs_session_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> sess_active);

  p_no_new_bits_in_session_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_active && $past(sess_active)) |-> ((stat_q & ~$past(stat_q)) == 8'h00));

  p_status_byte_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !ready) |=> (rd_data[7:0] == $past(stat_q)));

  p_int_has_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (stat_q != 8'h00));

  p_high_bits_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[7:3] == 5'b00000);

endmodule

bind hpi_irq_arb hpi_irq_arb_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .int_n          (int_n),
  .ready          (ready),
  .resume_req     (resume_req),
  .rd_data        (rd_data),
  .wake_pin       (wake_pin),
  .remote_wake_en (remote_wake_en),
  .sess_active    (sess_active),
  .stat_q         (stat_q),
  .fall_evt       (fall_evt)
);

// File: tb/hpi_irq_arb_test.sv
module hpi_irq_arb_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       selftest_done = 0, desc_present = 0, enum_done = 0, bus_reset = 0;
  logic       bus_resume = 0, wake_pin = 0, remote_wake_en = 0;
  logic [7:0] irq_en = 8'h00;
  logic       rd_req = 0;
  logic [7:0] req_data = 8'h00;
  logic       rd_strobe_n = 1'b1;
  logic [7:0] rd_data;
  logic       int_n, ready, resume_req;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [7:0] m_stat = 0, m_held = 0;
  bit         m_sess = 0;

  always #5 clk = ~clk;

  hpi_irq_arb uut (
    .clk(clk), .rst_n(rst_n), .selftest_done(selftest_done), .desc_present(desc_present),
    .enum_done(enum_done), .bus_reset(bus_reset), .bus_resume(bus_resume),
    .wake_pin(wake_pin), .remote_wake_en(remote_wake_en), .irq_en(irq_en),
    .rd_req(rd_req), .req_data(req_data), .rd_strobe_n(rd_strobe_n),
    .rd_data(rd_data), .int_n(int_n), .ready(ready), .resume_req(resume_req)
  );

  // kind: 0 selftest, 1 enum, 2 bus reset, 3 resume, 4 wake
  function automatic logic [7:0] ev_code(input int kind, input bit desc);
    case (kind)
      0: return desc ? 8'h02 : 8'h01;
      1, 2: return 8'h02;
      3: return 8'h04;
      default: return 8'h01;
    endcase
  endfunction

  function automatic bit exp_int_n();
    return (m_stat & irq_en) == 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ev(input int kind);
    @(negedge clk);
    case (kind)
      0: selftest_done = 1;
      1: enum_done = 1;
      2: bus_reset = 1;
      3: bus_resume = 1;
      default: wake_pin = 1;
    endcase
    if (m_sess) m_held |= ev_code(kind, desc_present);
    else        m_stat |= ev_code(kind, desc_present);
    @(negedge clk);
    chk(resume_req == (kind == 4 && remote_wake_en), "R9", resume_req, (kind == 4 && remote_wake_en));
    selftest_done = 0; enum_done = 0; bus_reset = 0; bus_resume = 0; wake_pin = 0;
    @(negedge clk);
    chk(resume_req == 0, "R9", resume_req, 0);
    chk(int_n == exp_int_n(), "R4/R8", int_n, exp_int_n());
  endtask

  task automatic strobe(output logic [7:0] got);
    @(negedge clk);
    rd_strobe_n = 0;
    repeat (4) @(negedge clk);
    got = rd_data;
    rd_strobe_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic status_read();
    logic [7:0] got, exp;
    exp = m_stat;
    strobe(got);
    chk(got == exp, "R5", got, exp);
    m_stat &= ~exp;
    chk(int_n == exp_int_n(), "R5", int_n, exp_int_n());
  endtask

  task automatic session(input logic [7:0] val, input int inject, input bit dup);
    logic [7:0] got, exp;
    bit smode;
    @(negedge clk);
    rd_req = 1; req_data = val;
    smode = (m_stat & irq_en) != 0;
    m_sess = 1;
    @(negedge clk);
    rd_req = 0; req_data = ~val;
    chk(ready == !smode, smode ? "R7" : "R6", ready, !smode);
    if (dup) begin
      rd_req = 1;
      @(negedge clk);
      rd_req = 0;
      chk(ready == !smode, "R10", ready, !smode);
    end
    if (inject >= 0) pulse_ev(inject);
    if (smode) begin
      exp = m_stat;
      strobe(got);
      chk(got == exp, "R7", got, exp);
      m_stat &= ~exp;
      chk(ready == 1, "R7", ready, 1);
      chk(int_n == exp_int_n(), "R8", int_n, exp_int_n());
    end
    strobe(got);
    chk(got == val, dup ? "R10" : "R6", got, val);
    m_stat |= m_held; m_held = 0; m_sess = 0;
    chk(ready == 0, "R6", ready, 0);
    chk(int_n == exp_int_n(), "R8", int_n, exp_int_n());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int_n == 1 && ready == 0 && resume_req == 0 && rd_data == 0, "R1",
        {int_n, ready, resume_req, rd_data}, 11'h400);

    // R2: self-test routing with and without descriptor
    irq_en = 8'h07;
    pulse_ev(0);
    chk(int_n == 0, "R2", int_n, 0);
    status_read();
    desc_present = 1;
    pulse_ev(0);
    desc_present = 0;
    begin logic [7:0] g; strobe(g); chk(g == 8'h02, "R2", g, 8'h02); m_stat = 0; end

    // R3: each source alone
    for (int k = 1; k < 5; k++) begin
      logic [7:0] g;
      pulse_ev(k);
      strobe(g);
      chk(g == ev_code(k, 0), "R3", g, ev_code(k, 0));
      m_stat = 0;
    end

    // R4: disabled bit recorded, no interrupt
    irq_en = 8'h01;
    pulse_ev(3);
    chk(int_n == 1, "R4", int_n, 1);
    status_read();

    // R9: no resume request without remote wakeup, one with it
    remote_wake_en = 0; pulse_ev(4); status_read();
    remote_wake_en = 1; pulse_ev(4); status_read(); remote_wake_en = 0;

    // R6: data-first session; R7: status-first with injection; R8; R10
    irq_en = 8'h07;
    session(8'hA5, -1, 0);
    pulse_ev(1);
    session(8'h3C, 3, 0);
    session(8'h5A, 4, 1);
    status_read();

    // Random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      irq_en = $urandom & 8'h07;
      desc_present = $urandom & 1;
      remote_wake_en = $urandom & 1;
      if ($urandom % 2) pulse_ev($urandom % 5);
      op = $urandom % 3;
      if (op == 0) status_read();
      else if (op == 1) session($urandom, ($urandom % 2) ? int'($urandom % 5) : -1, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule